// File: doc/BRIEF.md
# Windowed Clock Frequency Meter

This block measures how fast one clock runs compared with another. A target clock and a slower fixed clock are each picked from a bank of sources by a 3-bit select. The block counts rising edges of the target clock over a window of whole fixed-clock periods. It then reports the count in a result register, and a busy flag shows when that count is final. A window-length value of N gives a window of N+1 fixed periods. For example, a 26 MHz target counted over one 32 kHz period gives about 794.

Software drives a level-style interface. A soft reset clears the meter. An enable starts a session and, when cleared, ends it. The block also drives the power gate of the fast reference source. On start it turns the gate on and waits a settle interval before it arms the meter. On shutdown it disarms the meter first and turns the gate off one settle interval later.

The window edges are produced in the fixed-clock domain. A two-flop synchronizer carries them into the target (counting) domain. Completion passes back to the system clock the same way. The count saturates instead of wrapping. The fixed clock is expected to be slower than the target clock.

Top module: `freq_meter`

## Requirements
- R1: With window value N, the count equals the number of target rising edges within N+1 consecutive fixed-clock periods. When the period ratio is an integer and the edges never coincide, this is exactly ratio*(N+1).
- R2: The target select code picks `tgt_clks[code]`. Codes 0..6 are crystal 32k, crystal-derived 32k, internal 32k oscillator, crystal-detect 32k, 26 MHz, 32k and test clock. Code 7 selects no clock.
- R3: The fixed select code picks `fix_clks[code]`. Codes 0..6 are 26 MHz, crystal-detect 32k, internal 32k, RTC 32k, regulator clock, one-second tick and 75 kHz. Code 7 selects no clock.
- R4: `busy` rises when the meter is armed. It falls in the same cycle that `result` takes the new count, and `result` changes at no other time except soft reset.
- R5: The count saturates at 65535 and does not wrap.
- R6: While `sw_rst` is high, `result` reads 0, `busy` is low and `ref_en` is low. `result` stays 0 after release until a measurement completes.
- R7: `ref_en` rises the cycle after `meter_en` is sampled high. `busy` rises no earlier than SETTLE cycles after `ref_en`, and exactly SETTLE cycles after it when the meter is idle.
- R8: Clearing `meter_en` drops `busy` on the next edge. `ref_en` falls exactly SETTLE cycles after that edge, and never while `busy` is high.
- R9: A session ended before completion leaves `result` unchanged. The next session produces a correct fresh count.
- R10: After a measurement completes, `result` holds and no new measurement starts while `meter_en` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the control interface |
| rst_n | input | 1 | Active-low hard reset |
| sw_rst | input | 1 | Soft reset, active high, clears result and busy |
| meter_en | input | 1 | Session enable |
| win_len | input | WIN_W | Window length minus one, in fixed-clock periods |
| tgt_sel | input | SEL_W | Target clock select code |
| fix_sel | input | SEL_W | Fixed clock select code |
| tgt_clks | input | 2**SEL_W | Target clock source bank |
| fix_clks | input | 2**SEL_W | Fixed clock source bank |
| busy | output | 1 | Measurement in progress |
| result | output | CNT_W | Last completed count |
| ref_en | output | 1 | Power gate for the fast reference source |

## Verification
The bench runs several target/fixed pairs with integer period ratios and window lengths of 0, 1, 3 and 70. The last of these saturates. A window off by one period would give a count that is wrong by a full ratio, and a wrapping counter would give a small value in the long run. The bench measures the settle latencies on start and stop to the exact cycle, so a gate that moves early or late is caught. It also ends a session in the middle of a window and then reruns. A design that captured the partial count, or that left stale completion state, would show a changed result or a wrong second count. A soft reset applied after a valid result must bring the result to zero and keep it there.

// File: rtl/freq_meter.sv
`timescale 1ns/1ps
module freq_meter #(
  parameter int SEL_W  = 3,
  parameter int WIN_W  = 16,
  parameter int CNT_W  = 16,
  parameter int SETTLE = 2600
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sw_rst,
  input  logic                    meter_en,
  input  logic [WIN_W-1:0]        win_len,
  input  logic [SEL_W-1:0]        tgt_sel,
  input  logic [SEL_W-1:0]        fix_sel,
  input  logic [(1<<SEL_W)-1:0]   tgt_clks,
  input  logic [(1<<SEL_W)-1:0]   fix_clks,
  output logic                    busy,
  output logic [CNT_W-1:0]        result,
  output logic                    ref_en
);
  localparam int SCNT_W = $clog2(SETTLE + 1);
  localparam logic [SCNT_W-1:0] S_LAST = SCNT_W'(SETTLE - 1);
  localparam logic [CNT_W-1:0]  C_MAX  = {CNT_W{1'b1}};

  typedef enum logic [2:0] {S_IDLE, S_ON, S_RUN, S_DONE, S_OFF} sys_st_e;
  typedef enum logic [1:0] {F_IDLE, F_OPEN, F_CLOSED} fix_st_e;

  logic rst_all_n, tgt_ck, fix_ck, arm, win_open, f_act;
  assign rst_all_n = rst_n & ~sw_rst;
  assign tgt_ck    = tgt_clks[tgt_sel];
  assign fix_ck    = fix_clks[fix_sel];

  sys_st_e           st;
  logic [SCNT_W-1:0] scnt;
  logic [CNT_W-1:0]  res_q;
  logic [1:0]        done_sy, fact_sy;

  fix_st_e           fst;
  logic [1:0]        arm_fs;
  logic [WIN_W-1:0]  pcnt;

  logic [1:0]        arm_ts, win_ts;
  logic              t_seen, t_done;
  logic [CNT_W-1:0]  t_cnt;

  assign arm      = (st == S_RUN) || (st == S_DONE);
  assign win_open = (fst == F_OPEN);
  assign f_act    = (fst != F_IDLE);
  assign busy     = (st == S_RUN);
  assign ref_en   = (st != S_IDLE);
  assign result   = res_q;

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      st      <= S_IDLE;
      scnt    <= '0;
      res_q   <= '0;
      done_sy <= '0;
      fact_sy <= '0;
    end else begin
      done_sy <= {done_sy[0], t_done};
      fact_sy <= {fact_sy[0], f_act};
      case (st)
        S_IDLE: if (meter_en) begin
          st   <= S_ON;
          scnt <= '0;
        end
        S_ON: begin
          if (!meter_en) begin
            st   <= S_OFF;
            scnt <= '0;
          end else if (scnt == S_LAST) begin
            if (!done_sy[1] && !fact_sy[1]) st <= S_RUN;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        S_RUN: begin
          if (!meter_en) begin
            st   <= S_OFF;
            scnt <= '0;
          end else if (done_sy[1]) begin
            res_q <= t_cnt;
            st    <= S_DONE;
          end
        end
        S_DONE: if (!meter_en) begin
          st   <= S_OFF;
          scnt <= '0;
        end
        S_OFF: begin
          if (scnt == S_LAST) st <= S_IDLE;
          else                scnt <= scnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge fix_ck or negedge rst_all_n) begin
    if (!rst_all_n) begin
      arm_fs <= '0;
      fst    <= F_IDLE;
      pcnt   <= '0;
    end else begin
      arm_fs <= {arm_fs[0], arm};
      if (!arm_fs[1]) begin
        fst <= F_IDLE;
      end else begin
        case (fst)
          F_IDLE: begin
            fst  <= F_OPEN;
            pcnt <= '0;
          end
          F_OPEN: begin
            if (pcnt == win_len) fst <= F_CLOSED;
            else                 pcnt <= pcnt + 1'b1;
          end
          default: fst <= F_CLOSED;
        endcase
      end
    end
  end

  always_ff @(posedge tgt_ck or negedge rst_all_n) begin
    if (!rst_all_n) begin
      arm_ts <= '0;
      win_ts <= '0;
      t_seen <= 1'b0;
      t_done <= 1'b0;
      t_cnt  <= '0;
    end else begin
      arm_ts <= {arm_ts[0], arm};
      win_ts <= {win_ts[0], win_open};
      if (!arm_ts[1]) begin
        t_seen <= 1'b0;
        t_done <= 1'b0;
        t_cnt  <= '0;
      end else if (win_ts[1]) begin
        t_seen <= 1'b1;
        if (t_cnt != C_MAX) t_cnt <= t_cnt + 1'b1;
      end else if (t_seen) begin
        t_done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/freq_meter_chk.sv
`timescale 1ns/1ps
module freq_meter_chk #(
  parameter int CNT_W  = 16,
  parameter int SETTLE = 2600
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_rst,
  input logic             busy,
  input logic             ref_en,
  input logic [CNT_W-1:0] result
);
  int ref_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ref_cnt <= 0;
    else if (!ref_en)                  ref_cnt <= 0;
    else if (ref_cnt < SETTLE)         ref_cnt <= ref_cnt + 1;
  end

  AST_SOFT_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |-> (result == '0 && !busy && !ref_en));                     // R6
  AST_BUSY_UNDER_GATE: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    busy |-> ref_en);                                                   // R7
  AST_SETTLE_BEFORE_ARM: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    $rose(busy) |-> ref_cnt >= SETTLE - 1);                             // R7
  AST_GATE_OFF_AFTER_METER: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    $fell(ref_en) |-> $past(!busy));                                    // R8
  AST_RESULT_ON_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    !$stable(result) |-> $fell(busy));                                  // R4
endmodule

bind freq_meter freq_meter_chk #(.CNT_W(CNT_W), .SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
  .busy(busy), .ref_en(ref_en), .result(result)
);

// File: tb/freq_meter_test.sv
`timescale 1ns/1ps
module freq_meter_test;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sw_rst = 1'b0, meter_en = 1'b0;
  logic [15:0] win_len = '0;
  logic [2:0] tgt_sel = '0, fix_sel = '0;
  logic t50 = 0, t40 = 0, t20 = 0, t10 = 0, t1 = 0;
  logic f1k = 0, f2k = 0, f4k = 0;
  logic [7:0] tgt_clks, fix_clks;
  logic busy, ref_en;
  logic [15:0] result;

  always #2.5 clk = ~clk;
  always #25  t50 = ~t50;
  always #20  t40 = ~t40;
  always #10  t20 = ~t20;
  always #5   t10 = ~t10;
  initial begin #0.25; forever #0.5 t1 = ~t1; end
  initial begin #3;  forever begin f1k = 1; #500;  f1k = 0; #500;  end end
  initial begin #7;  forever begin f2k = 1; #1000; f2k = 0; #1000; end end
  initial begin #11; forever begin f4k = 1; #2000; f4k = 0; #2000; end end

  assign tgt_clks = {1'b0, t1, t40, t10, t40, t20, t40, t50};
  assign fix_clks = {1'b0, f4k, f2k, f4k, f4k, f1k, f4k, f4k};

  freq_meter #(.SETTLE(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .meter_en(meter_en),
    .win_len(win_len), .tgt_sel(tgt_sel), .fix_sel(fix_sel),
    .tgt_clks(tgt_clks), .fix_clks(fix_clks),
    .busy(busy), .result(result), .ref_en(ref_en)
  );

  int checks = 0, errors = 0, cycles = 0;
  int exp_q[$];
  string tag_q[$];
  logic pb = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (pb && !busy && meter_en) begin
      if (exp_q.size() == 0) begin
        check(0, "R4 unexpected completion", result, -1);
      end else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(result == e, t, result, e);
      end
    end
    pb = busy;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      check(0, "watchdog", cycles, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic start_run(input int ts, input int fs, input int n, output int lat_ref, output int lat_busy);
    @(negedge clk);
    tgt_sel = 3'(ts); fix_sel = 3'(fs); win_len = 16'(n);
    meter_en = 1'b1;
    lat_ref = 0; lat_busy = 0;
    do begin
      @(negedge clk);
      lat_busy++;
      if (ref_en && lat_ref == 0) lat_ref = lat_busy;
    end while (!busy);
  endtask

  task automatic run_meas(input int ts, input int fs, input int n, input int exp, input string tag);
    int lr, lb;
    exp_q.push_back(exp); tag_q.push_back(tag);
    start_run(ts, fs, n, lr, lb);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic stop_run(output int lat);
    @(negedge clk);
    meter_en = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (ref_en);
  endtask

  initial begin
    int lr, lb, lo;
    int held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(result == 0, "R6 reset result", result, 0);
    check(busy == 0, "R6 reset busy", busy, 0);
    check(ref_en == 0, "R6 reset gate", ref_en, 0);

    exp_q.push_back(100); tag_q.push_back("R1 10ns vs 1000ns N=0");
    start_run(4, 2, 0, lr, lb);
    check(lr == 1, "R7 gate latency", lr, 1);
    check(lb == SETTLE + 1, "R7 busy latency", lb, SETTLE + 1);
    while (busy) @(negedge clk);
    repeat (600) @(negedge clk);
    check(result == 100 && !busy, "R10 result held", result, 100);
    stop_run(lo);
    check(lo == SETTLE + 1, "R8 gate off latency", lo, SETTLE + 1);

    run_meas(4, 2, 3, 400, "R1 window N=3");
    stop_run(lo);
    run_meas(0, 2, 0, 20, "R2 target code 0");
    stop_run(lo);
    run_meas(2, 2, 0, 50, "R2 target code 2");
    stop_run(lo);
    run_meas(4, 5, 0, 200, "R3 fixed code 5");
    stop_run(lo);
    run_meas(6, 2, 0, 1000, "R1 1ns target N=0");
    stop_run(lo);
    run_meas(6, 2, 70, 65535, "R5 saturation");
    stop_run(lo);
    run_meas(2, 5, 1, 200, "R1 R3 20ns vs 2000ns N=1");
    stop_run(lo);

    held = result;
    start_run(4, 2, 20, lr, lb);
    repeat (300) @(negedge clk);
    stop_run(lo);
    check(lo == SETTLE + 1, "R8 abort gate latency", lo, SETTLE + 1);
    check(result == held, "R9 abort keeps result", result, held);
    run_meas(4, 2, 1, 200, "R9 fresh run after abort");
    stop_run(lo);

    @(negedge clk);
    sw_rst = 1'b1;
    repeat (3) @(negedge clk);
    check(result == 0, "R6 soft reset result", result, 0);
    check(!busy && !ref_en, "R6 soft reset flags", {busy, ref_en}, 0);
    sw_rst = 1'b0;
    repeat (5) @(negedge clk);
    check(result == 0, "R6 result after release", result, 0);

    check(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule